// File: doc/BRIEF.md
# Redundant-binary to two's-complement converter

This block takes a signed-digit number in redundant-binary form and returns it as an ordinary two's-complement word of the same width. Each digit position carries two bits, a positive part and a negative part, so the digit value is one of +1, 0 or -1. The two bits are never both set. The word is the positive vector minus the negative vector, taken modulo 2^W. It is the last stage after a tree of redundant adders has reduced all partial products of a multiplier to one signed-digit result.

The conversion is the sum of the positive vector, the bitwise inverse of the negative vector and a constant one. Because a digit never has both bits set, this sum needs no full adders. Each digit's carry out is picked by a 2:1 multiplexer: a nonzero digit sets the carry to its positive bit, and a zero digit passes the incoming carry through. Each result bit is the incoming carry, inverted when the digit is zero. The final carry is dropped. The converted word is registered once, so the result appears one clock edge after the operands are sampled.

Top module: `rb2bin_conv`

## Requirements
- R1: For any legal operand pair, `res_o` equals (`pos_i` - `neg_i`) mod 2^W one rising clock edge after the pair is sampled.
- R2: When every digit is zero (`pos_i` = 0 and `neg_i` = 0), the result is 0.
- R3: When every digit is -1 (`pos_i` = 0, `neg_i` all ones), the result is 1.
- R4: When no digit is negative (`neg_i` = 0), the result equals `pos_i`.
- R5: The carry out of the top digit is discarded. For example, `pos_i` = 0 with `neg_i` = 1 gives all ones, and the most negative cases wrap without any extra output.
- R6: The carry into digit 0 is fixed at 1. A zero digit at position 0 yields bit 0 = 0, and a nonzero digit at position 0 yields bit 0 = 1.
- R7: While `rst_n` is low at a rising edge, `res_o` is 0 after that edge, whatever the operands are.
- R8: Legal operands never have the same bit position set in both `pos_i` and `neg_i`. The block relies on this rule, and an assertion guards it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the result register |
| pos_i | input | W | Positive bit of every digit |
| neg_i | input | W | Negative bit of every digit |
| res_o | output | W | Two's-complement result, registered |

## Verification
In a single conversion, a nonzero digit can force the carry at the same time as a long run of zero digits above it passes that carry upward. This is the case where the multiplexer chain can go wrong. It is provoked with patterns that hold one nonzero digit at the bottom, or at a chosen position, and only zero digits above it, and with random legal digit mixes. Every result is judged against a plain subtraction modulo 2^W. Reset is also made to coincide with a nonzero operand pair, and the register must still read zero.

// File: rtl/rb2bin_pkg.sv
package rb2bin_pkg;

    // Digit encoding as {positive bit, negative bit}
    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_NEG  = 2'b01,
        DIG_POS  = 2'b10,
        DIG_BAD  = 2'b11
    } rb_digit_e;

    // carry injected below digit 0 (the "+1" of the inverse-plus-one)
    localparam logic CARRY_SEED = 1'b1;

endpackage

// File: rtl/rb_sel_cell.sv
module rb_sel_cell
    import rb2bin_pkg::*;
(
    input  logic pos_i,
    input  logic neg_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);
    rb_digit_e dig;

    always_comb begin
        dig = rb_digit_e'({pos_i, neg_i});
        unique case (dig)
            DIG_POS: begin
                cout_o = 1'b1;
                sum_o  = cin_i;
            end
            DIG_NEG: begin
                cout_o = 1'b0;
                sum_o  = cin_i;
            end
            default: begin
                cout_o = cin_i;
                sum_o  = ~cin_i;
            end
        endcase
    end
endmodule

// File: rtl/rb_msb_cell.sv
module rb_msb_cell
    import rb2bin_pkg::*;
(
    input  logic pos_i,
    input  logic neg_i,
    input  logic cin_i,
    output logic sum_o
);
    rb_digit_e dig;

    always_comb begin
        dig = rb_digit_e'({pos_i, neg_i});
        unique case (dig)
            DIG_POS, DIG_NEG: sum_o = cin_i;
            default:          sum_o = ~cin_i;
        endcase
    end
endmodule

// File: rtl/rb_sel_chain.sv
module rb_sel_chain
    import rb2bin_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] pos_i,
    input  logic [W-1:0] neg_i,
    output logic [W-1:0] bin_o
);
    localparam int TOP = W - 1;

    logic [TOP:0] carry;

    assign carry[0] = CARRY_SEED;

    generate
        for (genvar g = 0; g < TOP; g++) begin : g_dig
            rb_sel_cell i_cell (
                .pos_i (pos_i[g]),
                .neg_i (neg_i[g]),
                .cin_i (carry[g]),
                .sum_o (bin_o[g]),
                .cout_o(carry[g+1])
            );
        end
    endgenerate

    rb_msb_cell i_msb (
        .pos_i(pos_i[TOP]),
        .neg_i(neg_i[TOP]),
        .cin_i(carry[TOP]),
        .sum_o(bin_o[TOP])
    );
endmodule

// File: rtl/rb2bin_conv.sv
module rb2bin_conv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pos_i,
    input  logic [W-1:0] neg_i,
    output logic [W-1:0] res_o
);
    typedef struct packed {
        logic [W-1:0] res;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] conv_w;

    rb_sel_chain #(.W(W)) i_chain (
        .pos_i(pos_i),
        .neg_i(neg_i),
        .bin_o(conv_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = conv_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o = st_q.res;

    // R8
    legal_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i & neg_i) == '0);

    // R1
    diff_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i & neg_i) == '0 |=> res_o == $past(pos_i - neg_i));

    // R2
    all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i == '0 && neg_i == '0) |=> res_o == '0);

    // R3
    all_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i == '0 && neg_i == '1) |=> res_o == W'(1));

    // R4
    pos_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_i == '0) |=> res_o == $past(pos_i));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> res_o == '0);
endmodule

// File: tb/test_rb2bin_conv.sv
module test_rb2bin_conv;
    localparam int W    = 16;
    localparam int PER  = 10;
    localparam int WDOG = 50000;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pos_i = '0;
    logic [W-1:0] neg_i = '0;
    logic [W-1:0] res_o;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit ended = 0;

    rb2bin_conv #(.W(W)) i_rb2bin_conv (
        .clk(clk), .rst_n(rst_n), .pos_i(pos_i), .neg_i(neg_i), .res_o(res_o)
    );

    always #(PER/2) clk = ~clk;

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] p, input logic [W-1:0] n, input string tag);
        item_t it;
        @(negedge clk);
        pos_i = p;
        neg_i = n;
        it.exp = p - n;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: one edge after the driver's negedge the result is registered
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(res_o, it.exp, it.tag);
            end
        end
    end

    initial begin
        #(PER * WDOG);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(res_o, '0, "R7 reset state");
        rst_n = 1'b1;

        drive('0, '0, "R2 all zero digits");
        drive('0, '1, "R3 all minus-one digits");
        drive('1, '0, "R4 all plus-one digits");
        drive(16'h5a3c, '0, "R4 positive only");
        drive('0, W'(1), "R5 wrap to all ones");
        drive(W'(1), '1 << 1, "R5 wrap low plus");
        drive(16'h8000, 16'h0001, "R5 top digit plus");
        drive(16'h0001, 16'h8000, "R5 top digit minus");
        drive(W'(1), '0, "R6 bit0 plus digit");
        drive(16'h0100, '0, "R6 bit0 zero digit");
        drive('0, 16'h0100, "R6 bit0 zero under minus");
        drive(16'h00f0, 16'h0f00, "R1 mixed runs");

        // single nonzero digit followed by a run of zero digits
        for (int k = 0; k < W; k++) begin
            drive('0, W'(1) << k, "R1 lone minus digit");
            drive(W'(1) << k, '0, "R1 lone plus digit");
        end

        for (int r = 0; r < 300; r++) begin
            logic [W-1:0] p, n;
            p = '0;
            n = '0;
            for (int b = 0; b < W; b++) begin
                int sel;
                sel = $urandom_range(2);
                if (sel == 1) p[b] = 1'b1;
                else if (sel == 2) n[b] = 1'b1;
            end
            drive(p, n, "R1 random legal digits");
        end

        repeat (3) @(negedge clk);

        // reset coinciding with a nonzero operand
        pos_i = 16'h1234;
        neg_i = 16'h4000;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(res_o, '0, "R7 reset with live operand");
        @(negedge clk);
        rst_n = 1'b1;
        drive(16'h1234, 16'h4000, "R1 after reset");
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule